// File: doc/BRIEF.md
# Power-Good and Thermal Flag Logic

This block sits beside the start-up sequencer of a boost regulator. It turns the sequencer state, four die-temperature comparator flags, a current-limit flag and a slow time tick into two levels. The first is a power-good level, where 1 means good and 0 means fault, which a separate stage drives onto an open-drain pin. The second is a thermal-shutdown request that goes back to the sequencer.

Power good is only released once the sequencer has reached a running state. It is withdrawn in three cases: an early-warning thermal band with separate trip and release thresholds, an overload that has lasted a fixed number of ticks, or the sequencer leaving its running states. The thermal-shutdown request has its own hysteresis band. Every comparator flag passes through a synchronizer before it is used.

Top module: `pg_thermal_flags`

## Requirements
- R1: After reset, pg_o and tsd_req_o are both 0.
- R2: The sequencer state is encoded 0 off, 1 and 2 linear charge phases, 3 soft-start, 4 boost running, 5 bypass running, 6 fault (7 unused). Assume the state is 4 or 5, no thermal warning is latched and the overload timer has not expired, all as seen at a clock edge. Then pg_o is 1 after that edge.
- R3: When seq_state_i is any value other than 4 or 5, pg_o is 0 in the same cycle, with no clock edge needed.
- R4: Every comparator input (temp_gt150_i, temp_gt130_i, temp_gt120_i, temp_gt100_i, ilim_i) passes through a two-flop synchronizer. A level sampled at edge k is first used by the logic at edge k+2.
- R5: A synchronized temp_gt120_i of 1 latches a thermal warning. The warning holds until the synchronized temp_gt100_i is 0. While it is latched, pg_o is 0 from the following edge on. pg_o therefore falls three edges after temp_gt120_i rises, and it stays low while temp_gt100_i stays high.
- R6: The overload timer counts tick_i pulses while the synchronized ilim_i is 1. It returns to zero in any cycle where that flag is 0. Once it has counted OVL_TICKS (default 64) ticks, it holds there and pg_o goes to 0.
- R7: A synchronized temp_gt150_i of 1 sets tsd_req_o at the next edge, which is two edges after the input. tsd_req_o stays set until the synchronized temp_gt130_i is 0. If both conditions apply, set wins.
- R8: While seq_state_i is 0 (off), the warning latch, the shutdown request and the overload timer are cleared at each edge, and clearing overrides setting. tsd_req_o therefore reads 0 after one such edge, even if temp_gt130_i is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seq_state_i | input | 3 | Sequencer state, encoding in R2 |
| temp_gt150_i | input | 1 | Die above shutdown trip |
| temp_gt130_i | input | 1 | Die above shutdown release |
| temp_gt120_i | input | 1 | Die above warning trip |
| temp_gt100_i | input | 1 | Die above warning release |
| ilim_i | input | 1 | Current limit active |
| tick_i | input | 1 | One-cycle time base pulse (1 ms nominal) |
| pg_o | output | 1 | Power good level, 1 good, 0 fault |
| tsd_req_o | output | 1 | Thermal shutdown request |

## Verification
Each result has a fixed latency:
- A state change reaches pg_o in the same cycle when it takes power good away, and after one edge when it grants it.
- A temperature flag reaches tsd_req_o after two edges and pg_o after three.
- The overload timer expires OVL_TICKS counted ticks after the synchronized flag first counts, and pg_o follows one edge later.

The bench keeps a reference built from those latencies. It drives inputs and compares both outputs on the falling edge, so every registered result has settled and the combinational state gate reflects the inputs just applied. The phases are:
- a directed sweep of all eight state codes;
- walks through each hysteresis band;
- overload runs just short of and past the limit, under gapped ticks;
- a long pseudo-random run.

// File: rtl/pgt_pkg.sv
package pgt_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF    = 3'd0,
    SEQ_LIN1   = 3'd1,
    SEQ_LIN2   = 3'd2,
    SEQ_SOFT   = 3'd3,
    SEQ_BOOST  = 3'd4,
    SEQ_BYPASS = 3'd5,
    SEQ_FAULT  = 3'd6,
    SEQ_RSVD   = 3'd7
  } seq_state_e;

  typedef struct packed {
    logic hot;    // above shutdown trip
    logic warm;   // above shutdown release
    logic trip;   // above warning trip
    logic keep;   // above warning release
    logic ilim;   // current limit
  } cmp_flags_t;

  localparam int unsigned CMP_W = $bits(cmp_flags_t);

  function automatic logic seq_running(input seq_state_e s);
    return (s == SEQ_BOOST) || (s == SEQ_BYPASS);
  endfunction

  function automatic logic seq_off(input seq_state_e s);
    return s == SEQ_OFF;
  endfunction

endpackage

// File: rtl/pgt_sync.sv
module pgt_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[i] <= '0;
          else         stage_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[i] <= '0;
          else         stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pgt_hyst_latch.sv
module pgt_hyst_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,   // dominant clear
  input  logic set_i,   // upper threshold crossed
  input  logic hold_i,  // still above lower threshold
  output logic q_o
);

  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= 1'b0;
    else if (clr_i)   q_q <= 1'b0;
    else if (set_i)   q_q <= 1'b1;
    else if (!hold_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

endmodule

// File: rtl/pgt_ovl_timer.sv
module pgt_ovl_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic active_i,
  input  logic tick_i,
  output logic expired_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || !active_i)     cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIM);

endmodule

// File: rtl/pg_thermal_flags.sv
module pg_thermal_flags
  import pgt_pkg::*;
#(
  parameter int unsigned OVL_TICKS   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] seq_state_i,
  input  logic       temp_gt150_i,
  input  logic       temp_gt130_i,
  input  logic       temp_gt120_i,
  input  logic       temp_gt100_i,
  input  logic       ilim_i,
  input  logic       tick_i,
  output logic       pg_o,
  output logic       tsd_req_o
);

  seq_state_e state;
  logic       st_run, st_off;
  cmp_flags_t flags_raw, flags_s;
  logic       hot_s, cool_s;
  logic       warn_q, ovl_hit, pg_q;

  assign state  = seq_state_e'(seq_state_i);
  assign st_run = seq_running(state);
  assign st_off = seq_off(state);

  assign flags_raw = '{hot:  temp_gt150_i, warm: temp_gt130_i,
                       trip: temp_gt120_i, keep: temp_gt100_i,
                       ilim: ilim_i};

  pgt_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (flags_raw),
    .q_o   (flags_s)
  );

  assign hot_s  = flags_s.hot;
  assign cool_s = flags_s.warm;

  // shutdown band
  pgt_hyst_latch u_tsd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_off),
    .set_i (flags_s.hot),
    .hold_i(flags_s.warm),
    .q_o   (tsd_req_o)
  );

  // early-warning band
  pgt_hyst_latch u_warn (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_off),
    .set_i (flags_s.trip),
    .hold_i(flags_s.keep),
    .q_o   (warn_q)
  );

  pgt_ovl_timer #(.LIMIT(OVL_TICKS)) u_ovl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_off),
    .active_i (flags_s.ilim),
    .tick_i   (tick_i),
    .expired_o(ovl_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pg_q <= 1'b0;
    else         pg_q <= st_run && !warn_q && !ovl_hit;
  end

  // leaving the running states withdraws power good without waiting for an edge
  assign pg_o = pg_q && st_run;

endmodule

// File: rtl/pgt_flags_chk.sv
module pgt_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] seq_state_i,
  input logic       pg_o,
  input logic       tsd_req_o,
  input logic       warn_i,
  input logic       ovl_i,
  input logic       hot_s_i,
  input logic       cool_s_i
);

  logic run, off;
  assign run = (seq_state_i == 3'd4) || (seq_state_i == 3'd5);
  assign off = (seq_state_i == 3'd0);

  // R3
  pg_state_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !pg_o);

  // R2
  pg_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_o |-> $past(run));

  // R5
  warn_blocks_pg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_i |=> !pg_o);

  // R6
  ovl_blocks_pg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_i |=> !pg_o);

  // R7
  tsd_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tsd_req_o) |-> $past(hot_s_i));

  // R7
  tsd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsd_req_o && cool_s_i && !off) |=> tsd_req_o);

  // R8
  off_clears_tsd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off |=> !tsd_req_o);

endmodule

bind pg_thermal_flags pgt_flags_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .seq_state_i(seq_state_i),
  .pg_o       (pg_o),
  .tsd_req_o  (tsd_req_o),
  .warn_i     (warn_q),
  .ovl_i      (ovl_hit),
  .hot_s_i    (hot_s),
  .cool_s_i   (cool_s)
);

// File: tb/pg_thermal_flags_test.sv
`timescale 1ns/1ps
module pg_thermal_flags_test;

  localparam int unsigned LIM = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] st = 3'd0;
  logic       t150 = 0, t130 = 0, t120 = 0, t100 = 0, ilim = 0, tick = 0;
  logic       pg, tsd;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  string tag  = "R1";

  always #2 clk = ~clk;

  pg_thermal_flags #(.OVL_TICKS(LIM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .seq_state_i(st),
    .temp_gt150_i(t150), .temp_gt130_i(t130), .temp_gt120_i(t120),
    .temp_gt100_i(t100), .ilim_i(ilim), .tick_i(tick),
    .pg_o(pg), .tsd_req_o(tsd)
  );

  // reference from the stated latencies (R2..R8)
  logic [4:0] d1, d2;           // {150,130,120,100,ilim} after one and two edges
  logic       m_warn, m_tsd, m_pgq;
  int         m_cnt;
  logic       m_run, m_off;
  assign m_run = (st == 3'd4) || (st == 3'd5);
  assign m_off = (st == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= '0; d2 <= '0; m_warn <= 0; m_tsd <= 0; m_pgq <= 0; m_cnt <= 0;
    end else begin
      d1 <= {t150, t130, t120, t100, ilim};
      d2 <= d1;
      m_tsd  <= m_off ? 1'b0 : d2[4] ? 1'b1 : !d2[3] ? 1'b0 : m_tsd;
      m_warn <= m_off ? 1'b0 : d2[2] ? 1'b1 : !d2[1] ? 1'b0 : m_warn;
      if (m_off || !d2[0])         m_cnt <= 0;
      else if (tick && m_cnt < LIM) m_cnt <= m_cnt + 1;
      m_pgq <= m_run && !m_warn && (m_cnt != LIM);
    end
  end

  task automatic cmp();
    logic epg;
    epg = m_pgq && m_run;
    vectors += 2;
    if (pg !== epg) begin
      fails++;
      $display("FAIL %s pg_o actual=%b expected=%b t=%0t", tag, pg, epg, $time);
    end
    if (tsd !== m_tsd) begin
      fails++;
      $display("FAIL %s tsd_req_o actual=%b expected=%b t=%0t", tag, tsd, m_tsd, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp();
    end
  endtask

  task automatic fin();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    fin();
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset values
    tag = "R1";
    step(3);
    rst_n = 1'b1;
    step(2);

    // R2 / R3: sweep every state code, entering each from running
    for (int s = 0; s < 8; s++) begin
      tag = (s == 4 || s == 5) ? "R2" : "R3";
      st = 3'd4; step(3);
      st = 3'(s); step(4);
    end

    // R5: warning band walk; R4 latency shows in the compare cycle
    tag = "R5";
    st = 3'd5; step(3);
    t100 = 1; step(3);
    t120 = 1; step(1); tag = "R4"; step(4);
    tag = "R5";
    t120 = 0; step(6);
    t100 = 0; step(6);

    // R7: shutdown band walk
    tag = "R7";
    t130 = 1; step(2);
    t150 = 1; step(4);
    t150 = 0; step(6);
    t130 = 0; step(5);
    t150 = 1; t130 = 0; step(4);   // set wins over missing hold
    t150 = 0; step(4);

    // R6: overload just short of the limit, then past it
    tag = "R6";
    st = 3'd4; tick = 1; step(2);
    ilim = 1; step(LIM);
    ilim = 0; step(3);
    ilim = 1; step(LIM + 6);
    ilim = 0; step(4);
    // gapped ticks
    ilim = 1;
    for (int i = 0; i < 3 * LIM; i++) begin tick = i[0]; step(1); end
    ilim = 0; tick = 1; step(4);

    // R8: off clears latches even with release flags high
    tag = "R8";
    t130 = 1; t150 = 1; t100 = 1; t120 = 1; ilim = 1; step(5);
    t150 = 0; t120 = 0;
    st = 3'd0; step(3);
    st = 3'd4; step(6);
    t130 = 0; t100 = 0; ilim = 0; step(4);

    // R4 and all others: pseudo-random run
    tag = "R4";
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd0) st = 3'(lfsr[6:4]);
      else if (lfsr[3:0] < 4'd3) st = 3'd4;
      t150 = lfsr[7] & lfsr[8] & lfsr[9];
      t130 = t150 | (lfsr[9] & lfsr[10]);
      t120 = lfsr[11] & lfsr[12] & lfsr[13];
      t100 = t120 | (lfsr[13] & lfsr[14]);
      ilim = (i % 400) < 300 ? 1'b1 : lfsr[15];
      tick = lfsr[2] | lfsr[5];
      step(1);
    end
    fin();
  end

endmodule